// File: doc/BRIEF.md
# Interrupt Source Steering Register

This block is a single memory-mapped control register that steers a set of level-sensitive interrupt sources onto a smaller set of numbered interrupt request lines. Each source owns a small routing field in the register. A field of zero turns the source off. A non-zero field names the output line that the source drives, and the line number is the field value minus one.

Every request line is the OR of all active sources whose field selects it. A second output gives the number of the highest active line plus one, or zero when no line is active. It is meant for a processor that takes its interrupt priority as an encoded value on a few pins. Software reads and writes the register over a plain single-register bus port. To change one source, software reads the register, clears that source's field, ORs in the new value and writes the result back.

Top module: `irq_steer_reg`

## Requirements
- R1: After reset the register reads as zero and no request line is active, whatever the source inputs are.
- R2: A write stores the routing fields. A read returns them at a stride of 4 bits, with source k in bits [4k+2:4k]. Bit 4k+3 of every nibble reads as zero, whatever value was written to it.
- R3: A source whose field is 0 drives no request line.
- R4: A source whose field holds n, with n from 1 to 7, drives request line n-1 while the source is active.
- R5: When several active sources select the same line, that line is the OR of them.
- R6: The level output equals the highest active line index plus one, and is 0 when no line is active.
- R7: A read-modify-write that replaces one source's field leaves the routing of every other source unchanged. The register holds its value in every cycle with no write.
- R8: Sources are level inputs with no latching. A request line falls in the same cycle that its last active source goes inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (spare bits zero) |
| src_active | input | 8 | Level interrupt sources, bit k is source k |
| irq_line | output | 7 | Request lines, bit j is line j |
| irq_level | output | 3 | Highest active line plus one, 0 if none |

## Verification
The hardest case to reach from the ports is a routing field being rewritten while other sources share or neighbour its line. The bench performs the read-modify-write sequence the way software does it and then drives each source on its own, which shows that only the targeted field moved. The vector table also covers every source stacked on one line, fields written with the spare nibble bit set, and a disabled source held active, so that a bad field decode or a bad priority encode shows up on the outputs.

// File: rtl/irq_steer_reg.sv
module irq_steer_reg #(
  parameter int NUM_SRC   = 8,
  parameter int FIELD_W   = 3,
  parameter int STRIDE    = 4,
  parameter int NUM_LINES = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [NUM_SRC*STRIDE-1:0]    bus_wdata,
  output logic [NUM_SRC*STRIDE-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]           src_active,
  output logic [NUM_LINES-1:0]         irq_line,
  output logic [$clog2(NUM_LINES+1)-1:0] irq_level
);
  localparam int REG_W = NUM_SRC * STRIDE;
  localparam int LVL_W = $clog2(NUM_LINES + 1);

  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m = '0;
    for (int k = 0; k < NUM_SRC; k++) m[STRIDE*k +: FIELD_W] = '1;
    return m;
  endfunction
  localparam logic [REG_W-1:0] RD_MASK = field_mask();

  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (bus_we) ctrl_q <= bus_wdata & RD_MASK;
  end

  assign bus_rdata = ctrl_q;

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
    logic [NUM_SRC-1:0] hit;
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign hit[k] = src_active[k] &&
                      (ctrl_q[STRIDE*k +: FIELD_W] == FIELD_W'(j + 1));
    end
    assign irq_line[j] = |hit;
  end

  always_comb begin
    irq_level = '0;
    for (int j = 0; j < NUM_LINES; j++)
      if (irq_line[j]) irq_level = LVL_W'(j + 1);
  end

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> bus_rdata == ($past(bus_wdata) & RD_MASK));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(bus_rdata));

  assert_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata == '0) |-> (irq_line == '0));

  assert_no_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active == '0) |-> (irq_line == '0));

  assert_level_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line == '0) == (irq_level == '0));

  assert_level_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> irq_line[irq_level - 1'b1]);
endmodule

// File: tb/irq_steer_reg_bench.sv
module irq_steer_reg_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_active = '0;
  logic [6:0]  irq_line;
  logic [2:0]  irq_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irq_steer_reg u_irq_steer_reg (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_active(src_active),
    .irq_line(irq_line), .irq_level(irq_level));

  // {ctrl, src, expected line, expected level}
  localparam int NV = 10;
  localparam logic [49:0] VEC [0:NV-1] = '{
    {32'h00000001, 8'h01, 7'h01, 3'd1},  // R4 R8
    {32'h00000001, 8'h00, 7'h00, 3'd0},  // R8 R6
    {32'h76543210, 8'hFF, 7'h7F, 3'd7},  // R4 R6
    {32'h76543210, 8'h01, 7'h00, 3'd0},  // R3
    {32'h76543210, 8'h0A, 7'h05, 3'd3},  // R4 R6
    {32'h33333333, 8'h80, 7'h04, 3'd3},  // R5
    {32'h33333333, 8'h81, 7'h04, 3'd3},  // R5
    {32'h12000000, 8'hC0, 7'h03, 3'd2},  // R4 R6
    {32'h0000000F, 8'h01, 7'h40, 3'd7},  // R2
    {32'h88888888, 8'hFF, 7'h00, 3'd0}   // R2 R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    src_active = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 lines after reset", {25'b0, irq_line}, 32'h0);
    check("R1 level after reset", {29'b0, irq_level}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      reg_write(VEC[v][49:18]);
      src_active = VEC[v][17:10];
      #1;
      check($sformatf("R2 readback vec%0d", v), bus_rdata, VEC[v][49:18] & 32'h77777777);
      check($sformatf("R4 lines vec%0d", v), {25'b0, irq_line}, {25'b0, VEC[v][9:3]});
      check($sformatf("R6 level vec%0d", v), {29'b0, irq_level}, {29'b0, VEC[v][2:0]});
    end

    // R7: read-modify-write of source 2 field to 5
    reg_write(32'h76543210);
    begin
      logic [31:0] rd;
      @(negedge clk);
      rd = bus_rdata;
      rd = (rd & ~(32'h7 << 8)) | (32'h5 << 8);
      reg_write(rd);
    end
    #1;
    check("R7 rmw readback", bus_rdata, 32'h76543510);
    src_active = 8'h04; #1;
    check("R7 new field line", {25'b0, irq_line}, 32'h10);
    check("R7 new field level", {29'b0, irq_level}, 32'd5);
    src_active = 8'h08; #1;
    check("R7 neighbour unchanged", {25'b0, irq_line}, 32'h04);
    src_active = 8'h02; #1;
    check("R7 lower neighbour unchanged", {25'b0, irq_line}, 32'h01);
    src_active = 8'h80; #1;
    check("R7 top source unchanged", {25'b0, irq_line}, 32'h40);
    repeat (3) @(negedge clk);
    check("R7 hold without write", bus_rdata, 32'h76543510);

    // R8: line drops as soon as the source goes away
    src_active = 8'h00; #1;
    check("R8 line drops", {25'b0, irq_line}, 32'h0);
    check("R6 level zero", {29'b0, irq_level}, 32'h0);

    // R1: reset clears a programmed register
    @(negedge clk); rst_n = 0; src_active = 8'hFF;
    @(negedge clk); rst_n = 1; #1;
    check("R1 rdata after second reset", bus_rdata, 32'h0);
    check("R1 lines after second reset", {25'b0, irq_line}, 32'h0);

    finish_run();
  end
endmodule